// File: doc/BRIEF.md
# Host-Paced Serial Ring Exchange

This block links a local pair of byte rings to a host over an asynchronous serial line (8 data bits, no parity, one stop bit, least significant bit first). The FPGA side never starts a transfer by itself. Each correctly framed byte that arrives from the host goes into a receive ring. Exactly one byte then goes back to the host, taken from the head of a transmit ring. The two sides therefore behave as one large ring, with the host setting the pace.

Application logic fills the transmit ring and drains the receive ring through simple FIFO-style ports. The receive read port is show-ahead: `app_rd_data` always presents the oldest stored byte.

If the transmit ring is empty when a reply is due, the reply is a filler byte and a counter records the event. If the receive ring is full, the incoming byte is dropped and a sticky flag is set. A reply is still sent in that case.

The line is oversampled at sixteen ticks per bit. One tick lasts `SAMPLE_DIV` clocks. A start bit is confirmed at its middle, and every later bit is sampled at its centre.

Top module: `uart_ring_xchg`

## Requirements
- R1: A correctly framed byte on `rxd` (start bit 0, eight data bits LSB first, stop bit 1) is stored in the receive ring. Bytes are read from `app_rd_data` in arrival order.
- R2: Every accepted byte causes exactly one reply frame on `txd`. The frame is 8N1, LSB first, with each bit lasting 16*`SAMPLE_DIV` clocks. `txd` goes low on the clock after the stop bit is accepted.
- R3: The reply carries the oldest byte of the transmit ring, and that byte is removed from the ring.
- R4: When the transmit ring is empty, the reply is 0x00 and `tx_underflow_cnt` increases by one.
- R5: When the receive ring is full, an accepted byte is dropped and `rx_overflow` is set and stays set until reset. The stored bytes are unchanged, and the reply is still sent as in R3/R4.
- R6: A frame whose stop bit reads 0 stores nothing, gets no reply and leaves `tx_underflow_cnt` unchanged.
- R7: A low pulse on `rxd` shorter than half a bit is not taken as a start bit. It stores nothing and gets no reply.
- R8: `txd` idles high. Writing the transmit ring never starts a transmission by itself.
- R9: After reset, `txd` is 1, `app_rd_empty` is 1, `app_wr_full` is 0, `rx_overflow` is 0 and `tx_underflow_cnt` is 0.
- R10: The transmit ring holds `DEPTH` bytes. `app_wr_full` rises when it holds `DEPTH` bytes, and a write while full is ignored.
- R11: A read request while the receive ring is empty has no effect on later data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial data from the host |
| txd | output | 1 | Serial data to the host |
| app_wr_en | input | 1 | Push `app_wr_data` into the transmit ring |
| app_wr_data | input | 8 | Byte to queue for the host |
| app_wr_full | output | 1 | Transmit ring full |
| app_rd_en | input | 1 | Pop the oldest received byte |
| app_rd_data | output | 8 | Oldest received byte (show-ahead) |
| app_rd_empty | output | 1 | Receive ring empty |
| rx_overflow | output | 1 | Sticky: a byte was dropped on a full receive ring |
| tx_underflow_cnt | output | CNT_W | Number of filler replies sent |

## Verification
Results appear at three different times after a stimulus.

Ring status and show-ahead data change one clock after an `app_wr_en` or `app_rd_en` strobe. The bench samples them on the following falling edge.

A reply starts one clock after the host's stop bit is confirmed at mid-bit, so it begins while the host is still driving the second half of that stop bit. For this reason the bench runs its serial decoder alongside the sender. The decoder waits for the falling edge of `txd` and samples each bit half a bit time into it. It allows a timeout of forty bit times, and a timeout means no reply.

The counter, the overflow flag and the receive ring are checked only after both the host frame and the reply have completed. The exact one-clock launch is left to the bound property.

// File: rtl/uart_ring_xchg.sv
module uart_ring_xchg #(
  parameter int SAMPLE_DIV = 2,
  parameter int DEPTH      = 16,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  output logic             txd,
  input  logic             app_wr_en,
  input  logic [7:0]       app_wr_data,
  output logic             app_wr_full,
  input  logic             app_rd_en,
  output logic [7:0]       app_rd_data,
  output logic             app_rd_empty,
  output logic             rx_overflow,
  output logic [CNT_W-1:0] tx_underflow_cnt
);
  localparam int AW      = $clog2(DEPTH);
  localparam int DW      = $clog2(SAMPLE_DIV + 1);
  localparam int BIT_CYC = 16 * SAMPLE_DIV;
  localparam int BW      = $clog2(BIT_CYC + 1);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} rx_st_t;

  logic [DW-1:0] div_q;
  logic          tick;
  assign tick = (div_q == DW'(SAMPLE_DIV - 1));
  always_ff @(posedge clk)
    if (!rst_n || tick) div_q <= '0;
    else                div_q <= div_q + 1'b1;

  logic [1:0] sync_q;
  logic       rx_s, rx_last;
  assign rx_s = sync_q[1];
  always_ff @(posedge clk)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};

  rx_st_t     st;
  logic [3:0] tcnt;
  logic [2:0] nbit;
  logic [7:0] rsh;
  logic       rx_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; tcnt <= '0; nbit <= '0; rsh <= '0; rx_ok <= 1'b0; rx_last <= 1'b1;
    end else begin
      rx_ok <= 1'b0;
      if (tick) begin
        rx_last <= rx_s;
        case (st)
          IDLE: if (rx_last && !rx_s) begin st <= START; tcnt <= '0; end
          START:
            if (tcnt == 4'd7) begin
              tcnt <= '0; nbit <= '0;
              st   <= rx_s ? IDLE : DATA;
            end else tcnt <= tcnt + 1'b1;
          DATA:
            if (tcnt == 4'd15) begin
              tcnt <= '0;
              rsh  <= {rx_s, rsh[7:1]};
              if (nbit == 3'd7) st <= STOP;
              else              nbit <= nbit + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          STOP:
            if (tcnt == 4'd15) begin
              tcnt  <= '0;
              rx_ok <= rx_s;
              st    <= IDLE;
            end else tcnt <= tcnt + 1'b1;
        endcase
      end
    end
  end

  logic [7:0] rmem [DEPTH];
  logic [7:0] tmem [DEPTH];
  logic [AW:0] r_wp, r_rp, t_wp, t_rp;
  logic r_full, r_empty, t_full, t_empty;

  assign r_empty = (r_wp == r_rp);
  assign r_full  = (r_wp[AW] != r_rp[AW]) && (r_wp[AW-1:0] == r_rp[AW-1:0]);
  assign t_empty = (t_wp == t_rp);
  assign t_full  = (t_wp[AW] != t_rp[AW]) && (t_wp[AW-1:0] == t_rp[AW-1:0]);

  always_ff @(posedge clk) begin
    if (rx_ok && !r_full)     rmem[r_wp[AW-1:0]] <= rsh;
    if (app_wr_en && !t_full) tmem[t_wp[AW-1:0]] <= app_wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_wp <= '0; r_rp <= '0; t_wp <= '0; t_rp <= '0;
      rx_overflow <= 1'b0; tx_underflow_cnt <= '0;
    end else begin
      if (rx_ok && !r_full)      r_wp <= r_wp + 1'b1;
      if (rx_ok && r_full)       rx_overflow <= 1'b1;
      if (app_rd_en && !r_empty) r_rp <= r_rp + 1'b1;
      if (app_wr_en && !t_full)  t_wp <= t_wp + 1'b1;
      if (rx_ok && !t_empty)     t_rp <= t_rp + 1'b1;
      if (rx_ok && t_empty)      tx_underflow_cnt <= tx_underflow_cnt + 1'b1;
    end
  end

  assign app_rd_data  = rmem[r_rp[AW-1:0]];
  assign app_rd_empty = r_empty;
  assign app_wr_full  = t_full;

  logic [9:0]    tsh;
  logic [3:0]    left;
  logic [BW-1:0] bcnt;
  logic          tx_busy;
  assign tx_busy = (left != 4'd0);
  assign txd     = tx_busy ? tsh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsh <= '1; left <= '0; bcnt <= '0;
    end else if (rx_ok) begin
      tsh  <= {1'b1, t_empty ? 8'h00 : tmem[t_rp[AW-1:0]], 1'b0};
      left <= 4'd10;
      bcnt <= '0;
    end else if (tx_busy) begin
      if (bcnt == BW'(BIT_CYC - 1)) begin
        bcnt <= '0;
        tsh  <= {1'b1, tsh[9:1]};
        left <= left - 1'b1;
      end else bcnt <= bcnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_ring_xchg_chk.sv
module uart_ring_xchg_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             rx_ok,
  input logic             tx_busy,
  input logic             t_empty,
  input logic             r_full,
  input logic             app_rd_en,
  input logic             ovf,
  input logic [CNT_W-1:0] ucnt
);
  AST_REPLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |=> !txd); // R2
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R8
  AST_NO_UNPROMPTED_TX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(rx_ok)); // R8
  AST_UNDERFLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok && t_empty) |=> ucnt == $past(ucnt) + 1'b1); // R4
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ok |=> $stable(ucnt)); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ok && r_full) |=> ovf); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R5
  AST_RX_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (r_full && !app_rd_en) |=> r_full); // R5
endmodule

bind uart_ring_xchg uart_ring_xchg_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .txd(txd), .rx_ok(rx_ok), .tx_busy(tx_busy),
  .t_empty(t_empty), .r_full(r_full), .app_rd_en(app_rd_en),
  .ovf(rx_overflow), .ucnt(tx_underflow_cnt)
);

// File: tb/uart_ring_xchg_tb_top.sv
module uart_ring_xchg_tb_top;
  localparam int DIV   = 2;
  localparam int DEPTH = 16;
  localparam int BIT   = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic app_wr_en = 1'b0, app_rd_en = 1'b0;
  logic [7:0] app_wr_data = '0;
  logic txd, app_wr_full, app_rd_empty, rx_overflow;
  logic [7:0] app_rd_data, tx_underflow_cnt;
  int vecs = 0, errs = 0;

  always #4 clk = ~clk;

  uart_ring_xchg #(.SAMPLE_DIV(DIV), .DEPTH(DEPTH), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
    .app_wr_en(app_wr_en), .app_wr_data(app_wr_data), .app_wr_full(app_wr_full),
    .app_rd_en(app_rd_en), .app_rd_data(app_rd_data), .app_rd_empty(app_rd_empty),
    .rx_overflow(rx_overflow), .tx_underflow_cnt(tx_underflow_cnt));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    @(negedge clk) rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic get_reply(output logic [7:0] b, output bit got);
    int t = 0;
    b = '0; got = 1'b0;
    @(negedge clk);
    while (txd && t < 40 * BIT) begin @(negedge clk); t++; end
    if (!txd) begin
      repeat (BIT / 2) @(negedge clk);
      if (!txd) begin
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          b[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        got = txd;
      end
    end
  endtask

  task automatic xchg(input logic [7:0] hb, input bit stop_ok,
                      output logic [7:0] rb, output bit got);
    fork
      send_byte(hb, stop_ok);
      get_reply(rb, got);
    join
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk) app_wr_en = 1'b1; app_wr_data = b;
    @(negedge clk) app_wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(!app_rd_empty && app_rd_data == exp, req, app_rd_data, exp);
    app_rd_en = 1'b1;
    @(negedge clk) app_rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    bit got;
    int idle_low;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(txd == 1'b1, "R9 txd", txd, 1);
    chk(app_rd_empty == 1'b1, "R9 rd_empty", app_rd_empty, 1);
    chk(app_wr_full == 1'b0, "R9 wr_full", app_wr_full, 0);
    chk(rx_overflow == 1'b0, "R9 overflow", rx_overflow, 0);
    chk(tx_underflow_cnt == 8'd0, "R9 underflow", tx_underflow_cnt, 0);

    // R8: queueing alone sends nothing
    for (int i = 0; i < 3; i++) wr(8'h3C + 8'(i * 13));
    idle_low = 0;
    repeat (40 * BIT) begin @(negedge clk); if (!txd) idle_low++; end
    chk(idle_low == 0, "R8 unprompted", idle_low, 0);

    // R2 R3: replies carry queued bytes in order
    for (int i = 0; i < 3; i++) begin
      xchg(8'hA0 + 8'(i), 1'b1, rb, got);
      chk(got, "R2 reply present", got, 1);
      chk(rb == 8'h3C + 8'(i * 13), "R3 reply data", rb, 8'h3C + 8'(i * 13));
    end
    // R4: empty transmit ring gives filler
    for (int i = 0; i < 2; i++) begin
      xchg(8'h5A ^ 8'(i), 1'b1, rb, got);
      chk(got && rb == 8'h00, "R4 filler", rb, 0);
      chk(tx_underflow_cnt == 8'(i + 1), "R4 underflow count", tx_underflow_cnt, i + 1);
    end
    // R1: stored in arrival order
    for (int i = 0; i < 3; i++) rd_expect(8'hA0 + 8'(i), "R1 order");
    rd_expect(8'h5A, "R1 order");
    rd_expect(8'h5B, "R1 order");
    @(negedge clk);
    chk(app_rd_empty, "R1 drained", app_rd_empty, 1);

    // R11: read while empty does nothing
    @(negedge clk) app_rd_en = 1'b1;
    @(negedge clk) app_rd_en = 1'b0;
    xchg(8'hC3, 1'b1, rb, got);
    rd_expect(8'hC3, "R11 empty read");

    // R10: fill the transmit ring, extra write dropped
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk(!app_wr_full, "R10 not full early", app_wr_full, 0);
      wr(8'(i * 7 + 3));
    end
    @(negedge clk);
    chk(app_wr_full, "R10 full", app_wr_full, 1);
    wr(8'hEE);
    // R3 R10: sweep of sixteen exchanges
    for (int i = 0; i < DEPTH; i++) begin
      xchg(8'(255 - i * 11), 1'b1, rb, got);
      chk(got && rb == 8'(i * 7 + 3), "R3 sweep reply", rb, 8'(i * 7 + 3));
    end
    xchg(8'h77, 1'b1, rb, got);
    // R5: receive ring was full (16 bytes), byte dropped, reply still sent
    chk(got && rb == 8'h00, "R10 extra write dropped / R5 reply", rb, 0);
    chk(rx_overflow, "R5 overflow", rx_overflow, 1);
    chk(tx_underflow_cnt == 8'd4, "R5 underflow", tx_underflow_cnt, 4);
    for (int i = 0; i < DEPTH; i++) rd_expect(8'(255 - i * 11), "R5 contents kept");
    @(negedge clk);
    chk(app_rd_empty, "R5 drop", app_rd_empty, 1);
    chk(rx_overflow, "R5 sticky", rx_overflow, 1);

    // R6: bad stop bit
    xchg(8'h81, 1'b0, rb, got);
    chk(!got, "R6 no reply", got, 0);
    chk(app_rd_empty, "R6 not stored", app_rd_empty, 1);
    chk(tx_underflow_cnt == 8'd4, "R6 count unchanged", tx_underflow_cnt, 4);

    // R7: short glitch
    fork
      begin
        @(negedge clk) rxd = 1'b0;
        repeat (BIT / 4) @(negedge clk);
        rxd = 1'b1;
      end
      get_reply(rb, got);
    join
    chk(!got, "R7 no reply", got, 0);
    chk(app_rd_empty, "R7 not stored", app_rd_empty, 1);
    // R1: link still works after the glitch
    xchg(8'h19, 1'b1, rb, got);
    chk(got && rb == 8'h00, "R2 after glitch", rb, 0);
    rd_expect(8'h19, "R1 after glitch");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule